// File: doc/BRIEF.md
# Recency Stack with Configurable Insertion

This block keeps the replacement state of one set in a set-associative cache. The state is an ordered list of way indices, running from most recently used to least recently used. The enclosing cache controller uses it in two ways:

- On a hit, it reports the way index. The block moves that way to the most-recent end of the list.
- On a miss, it reads the victim way. This is always the way at the least-recent end. The block then records where the refilled line sits in the list.

Where a refilled line goes is chosen per access by a policy input. There are three policies:

- **Classic recency.** The new line always goes to the most-recent end.
- **Tail insertion.** The new line stays in the victim's least-recent slot.
- **Bimodal insertion.** The new line goes to the most-recent end only when a pseudo-random coin comes up, with a chance of 1 in 32. Otherwise it stays at the least-recent end.

The two non-classic policies protect the set from thrashing when the working set is larger than the cache. A line that is never reused then leaves without first pushing every other line one step toward eviction.

An access completes in a single cycle. The victim output is combinational from the stored order, and the new order is registered on the clock edge. Associativity is a parameter, with 16 ways as the default; 8 ways is also supported.

Top module: `recency_stack`

## Requirements
- R1: While `rst` is high at a rising clock edge, the order becomes way i at position i. Position 0 is most recent. The pseudo-random register is loaded with 16'hACE1.
- R2: `victim_way` always equals the way at the least-recent position (position WAYS-1) of the current order, under every policy.
- R3: On a hit (`acc_valid`=1, `acc_hit`=1), `acc_way` moves to position 0. Every entry that was ahead of it moves one step toward least recent. Entries behind it keep their positions. This holds under every policy.
- R4: On a miss with `policy` 0 or 3 (classic), the victim way moves to position 0 and all other entries move one step toward least recent.
- R5: On a miss with `policy` 1 (tail insertion), the order does not change.
- R6: On a miss with `policy` 2 (bimodal), the update follows R4 when the low 5 bits of the pseudo-random register are all zero before the access. Otherwise the order does not change.
- R7: The pseudo-random register is 16 bits wide. It advances exactly once per miss, under any policy, to {s[14:0], s[15]^s[13]^s[12]^s[10]}. On hits and idle cycles it holds its value.
- R8: When `acc_valid` is low, the order does not change.
- R9: The order is always a permutation: every way index appears exactly once.
- R10: The same behaviour holds with the parameter WAYS set to 8. In that case way indices are 3 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_hit | input | 1 | 1 = hit on `acc_way`, 0 = miss |
| acc_way | input | $clog2(WAYS) | Way that was hit (ignored on a miss) |
| policy | input | 2 | Insertion policy: 0/3 classic, 1 tail, 2 bimodal |
| victim_way | output | $clog2(WAYS) | Way to replace on a miss |
| order_o | output | WAYS*$clog2(WAYS) | Recency order; field p at bits [p*W +: W], p=0 most recent |

## Verification
A corrupted order shows on `order_o` at the very next sample after the access that caused it. It can also show as a duplicated way, which breaks the permutation property. If the least-recent entry is wrong, `victim_way` is wrong in the same cycle, before any clock edge.

A pseudo-random register that advances at the wrong time does not show immediately. It only surfaces at the next bimodal miss that takes the wrong side of the coin, so the bench runs long bimodal miss streams and keeps a model of the register.

// File: rtl/recency_pkg.sv
package recency_pkg;

    typedef enum logic [1:0] {
        INS_LRU     = 2'd0,
        INS_TAIL    = 2'd1,
        INS_BIMODAL = 2'd2,
        INS_LRU_ALT = 2'd3
    } ins_policy_e;

    typedef struct packed {
        logic valid;
        logic hit;
    } acc_kind_t;

    localparam int              COIN_LFSR_W   = 16;
    localparam logic [15:0]     COIN_SEED     = 16'hACE1;
    localparam logic [15:0]     COIN_TAPS     = 16'hB400;   // bits 15,13,12,10
    localparam int              COIN_BITS     = 5;          // 1 in 32

    // Decide whether a refilled line goes to the most-recent end.
    function automatic logic front_on_miss(ins_policy_e pol, logic coin);
        logic r;
        case (pol)
            INS_TAIL:    r = 1'b0;
            INS_BIMODAL: r = coin;
            default:     r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/recency_coin.sv
module recency_coin #(
    parameter int              WIDTH = recency_pkg::COIN_LFSR_W,
    parameter logic [WIDTH-1:0] SEED = recency_pkg::COIN_SEED,
    parameter logic [WIDTH-1:0] TAPS = recency_pkg::COIN_TAPS,
    parameter int              ZERO_BITS = recency_pkg::COIN_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic advance,
    output logic coin
);
    logic [WIDTH-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEED;
        else if (advance)
            state_q <= {state_q[WIDTH-2:0], ^(state_q & TAPS)};
    end

    assign coin = (state_q[ZERO_BITS-1:0] == '0);
endmodule

// File: rtl/recency_reorder.sv
module recency_reorder
    import recency_pkg::*;
#(
    parameter int WAYS  = 16,
    parameter int WAY_W = $clog2(WAYS),
    localparam int FLAT_W = WAYS * WAY_W
) (
    input  logic [FLAT_W-1:0] order_i,
    input  acc_kind_t         kind,
    input  logic [WAY_W-1:0]  acc_way,
    input  logic              front_miss,
    output logic [FLAT_W-1:0] order_o
);
    logic [WAY_W-1:0] cur [WAYS];
    logic [WAYS-1:0]  hit_vec;
    logic [WAYS-1:0]  move_vec;
    logic [WAYS-1:0]  shift_vec;
    logic [WAY_W-1:0] sel_way;

    always_comb begin
        for (int p = 0; p < WAYS; p++) begin
            cur[p]     = order_i[p*WAY_W +: WAY_W];
            hit_vec[p] = (cur[p] == acc_way);
        end
        sel_way = kind.hit ? acc_way : cur[WAYS-1];
        if (!kind.valid)
            move_vec = '0;
        else if (kind.hit)
            move_vec = hit_vec;
        else if (front_miss)
            move_vec = {1'b1, {(WAYS-1){1'b0}}};
        else
            move_vec = '0;
    end

    // shift_vec[p] is set when the moving entry sits at position p or deeper
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int p = WAYS-1; p >= 0; p--) begin
            acc          = acc | move_vec[p];
            shift_vec[p] = acc;
        end
    end

    always_comb begin
        order_o[0 +: WAY_W] = shift_vec[0] ? sel_way : cur[0];
        for (int p = 1; p < WAYS; p++)
            order_o[p*WAY_W +: WAY_W] = shift_vec[p] ? cur[p-1] : cur[p];
    end
endmodule

// File: rtl/recency_stack.sv
module recency_stack
    import recency_pkg::*;
#(
    parameter int WAYS = 16,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int FLAT_W = WAYS * WAY_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_hit,
    input  logic [WAY_W-1:0]  acc_way,
    input  logic [1:0]        policy,
    output logic [WAY_W-1:0]  victim_way,
    output logic [FLAT_W-1:0] order_o
);
    logic [FLAT_W-1:0] order_q;
    logic [FLAT_W-1:0] order_d;
    acc_kind_t         kind;
    logic              coin;
    logic              front_miss;

    assign kind.valid = acc_valid;
    assign kind.hit   = acc_hit;
    assign front_miss = front_on_miss(ins_policy_e'(policy), coin);

    recency_coin u_coin (
        .clk     (clk),
        .rst     (rst),
        .advance (acc_valid & ~acc_hit),
        .coin    (coin)
    );

    recency_reorder #(.WAYS(WAYS), .WAY_W(WAY_W)) u_reorder (
        .order_i    (order_q),
        .kind       (kind),
        .acc_way    (acc_way),
        .front_miss (front_miss),
        .order_o    (order_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WAYS; i++)
                order_q[i*WAY_W +: WAY_W] <= WAY_W'(i);
        end else begin
            order_q <= order_d;
        end
    end

    assign victim_way = order_q[(WAYS-1)*WAY_W +: WAY_W];
    assign order_o    = order_q;
endmodule

// File: rtl/recency_stack_chk.sv
module recency_stack_chk #(
    parameter int WAYS = 16,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int FLAT_W = WAYS * WAY_W
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_hit,
    input logic [WAY_W-1:0]  acc_way,
    input logic [1:0]        policy,
    input logic [WAY_W-1:0]  victim_way,
    input logic [FLAT_W-1:0] order_o
);
    logic [WAYS-1:0] seen;

    always_comb begin
        seen = '0;
        for (int p = 0; p < WAYS; p++)
            seen[order_o[p*WAY_W +: WAY_W]] = 1'b1;
    end

    assert_permutation_R9: assert property (@(posedge clk) disable iff (rst)
        &seen);

    assert_hit_to_front_R3: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_hit |=> order_o[0 +: WAY_W] == $past(acc_way));

    assert_victim_to_front_R4: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_hit && (policy == 2'd0 || policy == 2'd3)
        |=> order_o[0 +: WAY_W] == $past(victim_way));

    assert_tail_hold_R5: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_hit && policy == 2'd1 |=> $stable(order_o));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> $stable(order_o));
endmodule

bind recency_stack recency_stack_chk #(.WAYS(WAYS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_hit    (acc_hit),
    .acc_way    (acc_way),
    .policy     (policy),
    .victim_way (victim_way),
    .order_o    (order_o)
);

// File: tb/recency_stack_tb.sv
module recency_stack_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, acc_hit;
    logic [3:0]  way;
    logic [1:0]  policy;
    logic [3:0]  vic16;
    logic [63:0] ord16;
    logic [2:0]  vic8;
    logic [23:0] ord8;

    always #4 clk = ~clk;   // 125 MHz

    recency_stack #(.WAYS(16)) u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_way(way), .policy(policy), .victim_way(vic16), .order_o(ord16));

    // R10: 8-way variant driven by the same stream
    recency_stack #(.WAYS(8)) u_dut8 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_way(way[2:0]), .policy(policy), .victim_way(vic8), .order_o(ord8));

    int          m [2][16];
    int          nw [2] = '{16, 8};
    int          ww [2] = '{4, 3};
    logic [15:0] lf;
    int          n_chk = 0, n_err = 0, bip_front = 0;
    bit          done = 0;

    function automatic logic [63:0] flat(int k);
        logic [63:0] f = '0;
        for (int p = 0; p < nw[k]; p++)
            f |= 64'(m[k][p]) << (p * ww[k]);
        return f;
    endfunction

    function automatic bit perm_ok16(logic [63:0] o);
        logic [15:0] s = '0;
        for (int p = 0; p < 16; p++) s[o[p*4 +: 4]] = 1'b1;
        return &s;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++)
            for (int p = 0; p < 16; p++) m[k][p] = p;
        lf = 16'hACE1;
    endtask

    task automatic model_access(input bit h, input int w, input int pol);
        bit coin  = (lf[4:0] == 5'd0);
        bit front = (pol == 0) || (pol == 3) || (pol == 2 && coin);
        for (int k = 0; k < 2; k++) begin
            int n  = nw[k];
            int wk = w % n;
            if (h) begin
                int pos = 0;
                for (int p = 0; p < n; p++) if (m[k][p] == wk) pos = p;
                for (int p = pos; p > 0; p--) m[k][p] = m[k][p-1];
                m[k][0] = wk;
            end else if (front) begin
                int v = m[k][n-1];
                for (int p = n-1; p > 0; p--) m[k][p] = m[k][p-1];
                m[k][0] = v;
            end
        end
        if (!h) begin
            if (pol == 2 && coin) bip_front++;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};   // R7
        end
    endtask

    task automatic step(input bit v, input bit h, input int w, input int pol);
        string t;
        @(negedge clk);
        acc_valid = v; acc_hit = h; way = w[3:0]; policy = pol[1:0];
        #1;
        chk("R2", 64'(vic16), 64'(m[0][15]));
        chk("R10/R2", 64'(vic8), 64'(m[1][7]));
        if (!v)            t = "R8";
        else if (h)        t = "R3";
        else if (pol == 1) t = "R5";
        else if (pol == 2) t = "R6,R7";
        else               t = "R4";
        if (v) model_access(h, w, pol);
        @(posedge clk); #2;
        chk(t, ord16, flat(0));
        chk({"R10/", t}, 64'(ord8), flat(1));
        chk("R9", 64'(perm_ok16(ord16)), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; acc_valid = 1'b0; acc_hit = 1'b0; way = '0; policy = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        model_reset();
        #1;
        chk("R1", ord16, flat(0));
        chk("R10/R1", 64'(ord8), flat(1));
        chk("R1", 64'(vic16), 64'd15);

        // R5: tail insertion keeps order on repeated misses
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1);
        // R3: line at least-recent end promoted only when hit
        step(1, 1, 15, 1);
        step(1, 1, 15, 0);          // hit on most recent: unchanged
        step(1, 1, 7, 2);
        // R4: classic misses rotate victim to front
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
        step(1, 0, 0, 3);
        // R8: idle cycles
        for (int i = 0; i < 3; i++) step(0, 1, 5, 0);
        // R6, R7: bimodal misses until the coin has come up twice
        for (int i = 0; i < 3000 && bip_front < 2; i++) step(1, 0, 0, 2);
        chk("R6", 64'(bip_front >= 2), 64'd1);
        // mixed random traffic
        for (int i = 0; i < 1500; i++) begin
            int r = $urandom_range(0, 9);
            step(r != 0, r > 5, $urandom_range(0, 15), $urandom_range(0, 3));
        end
        @(negedge clk); acc_valid = 1'b0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule